// File: doc/BRIEF.md
# ACPI Sleep-State Control Sequencer

This block is the digital control core of a power manager that feeds three dual-supply rails: a 3.3 V rail, a 5 V rail and a memory rail. Each rail can be fed from the main supply through an active-state switch or from the standby supply through a standby switch. The block takes two active-low sleep requests and decodes them into four reported states: off, Active, S3 and S4/S5. It filters short glitches on those requests and waits out a bounded skew between the two lines. It refuses any move from one sleep state straight into the other.

Power-up is sequenced. The standby-good flag must hold for a power-on-reset extension. The 12 V-good flag must hold for a qualification time before any active-state switch closes. A memory-voltage select level is captured once, a fixed time after power-on reset releases. The two rail-enable configuration bits are captured only at defined instants and are then used to decide which standby switches close in sleep. Under-voltage flags from rails that are powered and settled, and an over-temperature flag, raise a sticky fault once they have persisted for a reporting delay. The fault turns every switch off. A shutdown input also turns every switch off and clears the fault. Analog regulation and comparators sit outside the block, and their results arrive as synchronous flags.

Top module: `sleep_seq_ctrl`

## Requirements
- R1: With sleep requests settled, `pstate` reports 1 (Active) when both `slp3_n` and `slp5_n` are high, 2 (S3) when only `slp3_n` is low, and 3 (S4/S5) when both are low. It reports 0 while powered off.
- R2: A request for S4/S5 while in S3, or a request for S3 while in S4/S5, is ignored. A sleep state is left only by a request for Active.
- R3: After `slp3_n` falls alone, the block keeps reporting Active for SKEW_CYC cycles. If `slp5_n` falls within that window, the block goes to S4/S5 without passing through S3.
- R4: A pulse on the sleep request lines that lasts fewer than DGL_CYC cycles causes no state change.
- R5: `cfg_en3` and `cfg_en5` are captured on entry to a sleep state, on power-on-reset release and on shutdown release. Changes made while asleep have no effect on the switches.
- R6: Switches are reported on the bus {rail3_act_en, rail3_sb_en, rail5_act_en, rail5_sb_en, mem_act_en, mem_sb_en}. In qualified Active this bus is 101010. In S3, mem_sb_en=1, rail3_sb_en equals the captured en3 and rail5_sb_en equals the captured en5. In S4/S5 the same holds except that mem_sb_en=0.
- R7: `mem_sel` takes the value of `msel_in` MSEL_DLY_CYC cycles after power-on-reset release and holds it from then on.
- R8: Active-state switches stay off until `v12_good` has stayed high for V12_QUAL_CYC cycles.
- R9: After reset every output is 0. The state stays off until `sb_good` has stayed high for POR_EXT_CYC cycles.
- R10: An under-voltage on a settled rail, or `ot_flag`, raises `fault` only once it has persisted for FLT_DLY_CYC cycles. A raised fault turns every switch off and stays raised until shutdown or power-on reset.
- R11: While `shdn` is high, all switches are off, `pstate` is 0 and `fault` is clear. On release the block returns to Active.
- R12: The active switch and the standby switch of one rail are never on in the same cycle.
- R13: An under-voltage flag (uv_flag bit 0 = 3.3 V rail, bit 1 = 5 V rail, bit 2 = memory rail) is ignored while that rail's switches are off or during its RAMP_CYC settling time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sb_good | input | 1 | Standby supply above its threshold |
| v12_good | input | 1 | 12 V supply above its threshold |
| slp3_n | input | 1 | Active-low S3 request |
| slp5_n | input | 1 | Active-low S4/S5 request |
| cfg_en3 | input | 1 | Allow 3.3 V standby switch in sleep |
| cfg_en5 | input | 1 | Allow 5 V standby switch in sleep |
| msel_in | input | 1 | Memory voltage select level (1 = 3.3 V) |
| shdn | input | 1 | Shutdown request, high forces all off |
| uv_flag | input | 3 | Under-voltage flags: 0=3.3 V, 1=5 V, 2=memory |
| ot_flag | input | 1 | Over-temperature flag |
| rail3_act_en | output | 1 | 3.3 V rail active-state switch |
| rail3_sb_en | output | 1 | 3.3 V rail standby switch |
| rail5_act_en | output | 1 | 5 V rail active-state switch |
| rail5_sb_en | output | 1 | 5 V rail standby switch |
| mem_act_en | output | 1 | Memory rail active-state switch |
| mem_sb_en | output | 1 | Memory rail standby switch |
| mem_sel | output | 1 | Captured memory voltage select |
| fault | output | 1 | Sticky fault indication |
| pstate | output | 2 | Reported state: 0 off, 1 Active, 2 S3, 3 S4/S5 |

## Verification
A wrong sequencer state shows within one cycle as a wrong `pstate` code. One cycle later it shows as a wrong switch pattern, because the switch register decodes the state directly. A broken skew counter or glitch filter shows up as a brief S3 or S4/S5 code during a window of a few cycles after the request edge, so those cases are watched on every cycle of the window instead of only once the lines have settled. A wrong captured configuration stays hidden until the next sleep entry and then shows as a wrong standby switch for the whole sleep period.

// File: rtl/sleepctl_pkg.sv
// Shared types for the sleep-state sequencer: sequencer states, decoded
// request codes and the per-rail switch bundle.
package sleepctl_pkg;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_ACT,
        ST_SKEW,
        ST_SLP3,
        ST_SLP5
    } seq_st_t;

    typedef enum logic [1:0] {
        REQ_ACT,
        REQ_S3,
        REQ_S5,
        REQ_BAD
    } req_t;

    typedef struct packed {
        logic v3_act;
        logic v3_sb;
        logic v5_act;
        logic v5_sb;
        logic mem_act;
        logic mem_sb;
    } rail_en_t;

    localparam logic [1:0] PS_OFF = 2'd0;
    localparam logic [1:0] PS_ACT = 2'd1;
    localparam logic [1:0] PS_S3  = 2'd2;
    localparam logic [1:0] PS_S5  = 2'd3;

    // Map the two active-low request lines to a request code.
    function automatic req_t decode_req(input logic s3n, input logic s5n);
        case ({s3n, s5n})
            2'b11:   return REQ_ACT;
            2'b01:   return REQ_S3;
            2'b00:   return REQ_S5;
            default: return REQ_BAD;
        endcase
    endfunction

endpackage

// File: rtl/sc_deglitch.sv
// Two-flop synchronizer followed by a stability filter. The output follows
// the input only after the synchronized input has differed from it for
// DGL_CYC consecutive cycles. Assumes DGL_CYC >= 1.
module sc_deglitch #(
    parameter int unsigned DGL_CYC = 4,
    parameter logic        RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    localparam int unsigned CW = (DGL_CYC < 2) ? 1 : $clog2(DGL_CYC);

    logic [1:0]    sync_q;
    logic [CW-1:0] cnt_q;

    // Synchronize, then accept a new level after it has been stable long enough.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= {2{RST_VAL}};
            dout   <= RST_VAL;
            cnt_q  <= '0;
        end else begin
            sync_q <= {sync_q[0], din};
            if (sync_q[1] == dout) begin
                cnt_q <= '0;
            end else if (cnt_q == CW'(DGL_CYC - 1)) begin
                dout  <= sync_q[1];
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    p_deglitch_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dout) |-> ($past(sync_q[1]) == dout));

endmodule

// File: rtl/sc_qualify.sv
// Persistence qualifier: qual rises once din has been high for LIMIT
// consecutive cycles and drops in the cycle after din falls.
// Assumes LIMIT >= 1.
module sc_qualify #(
    parameter int unsigned LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic qual
);
    localparam int unsigned CW = (LIMIT < 2) ? 1 : $clog2(LIMIT);

    logic [CW-1:0] cnt_q;

    // Count consecutive high cycles and flag when the limit is reached.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            qual  <= 1'b0;
        end else if (!din) begin
            cnt_q <= '0;
            qual  <= 1'b0;
        end else if (!qual) begin
            if (cnt_q == CW'(LIMIT - 1)) qual <= 1'b1;
            else                         cnt_q <= cnt_q + 1'b1;
        end
    end

    p_qual_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(qual) |-> $past(din));

endmodule

// File: rtl/sc_fsm.sv
// Sleep-state sequencer. From Active, an S4/S5 request is taken at once.
// An S3 request first waits SKEW_CYC cycles so that a late S5 edge can
// still resolve to S4/S5. Sleep states are left only through Active.
// Assumes the request inputs are already synchronized and deglitched.
module sc_fsm
    import sleepctl_pkg::*;
#(
    parameter int unsigned SKEW_CYC = 16
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    run,
    input  logic    s3n,
    input  logic    s5n,
    output seq_st_t state_q,
    output logic    sleep_entry
);
    localparam int unsigned CW = (SKEW_CYC < 2) ? 1 : $clog2(SKEW_CYC);

    seq_st_t       nxt;
    req_t          req;
    logic [CW-1:0] skew_q;

    assign req = decode_req(s3n, s5n);

    // Next-state selection, with illegal sleep-to-sleep moves held off.
    always_comb begin
        nxt = state_q;
        if (!run) begin
            nxt = ST_OFF;
        end else begin
            case (state_q)
                ST_OFF:  nxt = ST_ACT;
                ST_ACT: begin
                    if (req == REQ_S5)      nxt = ST_SLP5;
                    else if (req == REQ_S3) nxt = ST_SKEW;
                end
                ST_SKEW: begin
                    if (req == REQ_S5)      nxt = ST_SLP5;
                    else if (req == REQ_S3) begin
                        if (skew_q == CW'(SKEW_CYC - 1)) nxt = ST_SLP3;
                    end else                nxt = ST_ACT;
                end
                ST_SLP3, ST_SLP5: begin
                    if (req == REQ_ACT)     nxt = ST_ACT;
                end
                default: nxt = ST_OFF;
            endcase
        end
    end

    assign sleep_entry = ((nxt == ST_SLP3) || (nxt == ST_SLP5)) &&
                         !((state_q == ST_SLP3) || (state_q == ST_SLP5));

    // State register and skew-window counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            skew_q  <= '0;
        end else begin
            state_q <= nxt;
            if (state_q != ST_SKEW) skew_q <= '0;
            else                    skew_q <= skew_q + 1'b1;
        end
    end

    p_no_s3_to_s5_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SLP3) |=> (state_q != ST_SLP5));

    p_no_s5_to_s3_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SLP5) |=> (state_q != ST_SLP3));

    p_s3_after_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_SLP3) && ($past(state_q) != ST_SLP3)) |-> ($past(state_q) == ST_SKEW));

endmodule

// File: rtl/sleep_seq_ctrl.sv
// Top of the sleep-state sequencer. Qualifies the supplies, filters the
// sleep requests, runs the state sequencer, captures configuration and the
// memory select, delays and latches faults, and registers the rail switches.
// Assumes uv_flag, ot_flag, cfg_* and msel_in are synchronous to clk.
module sleep_seq_ctrl
    import sleepctl_pkg::*;
#(
    parameter int unsigned POR_EXT_CYC  = 660000,
    parameter int unsigned V12_QUAL_CYC = 10000000,
    parameter int unsigned MSEL_DLY_CYC = 600000,
    parameter int unsigned SKEW_CYC     = 40000,
    parameter int unsigned DGL_CYC      = 200,
    parameter int unsigned FLT_DLY_CYC  = 2000,
    parameter int unsigned RAMP_CYC     = 20000,
    parameter int unsigned N_RAIL       = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sb_good,
    input  logic       v12_good,
    input  logic       slp3_n,
    input  logic       slp5_n,
    input  logic       cfg_en3,
    input  logic       cfg_en5,
    input  logic       msel_in,
    input  logic       shdn,
    input  logic [2:0] uv_flag,
    input  logic       ot_flag,
    output logic       rail3_act_en,
    output logic       rail3_sb_en,
    output logic       rail5_act_en,
    output logic       rail5_sb_en,
    output logic       mem_act_en,
    output logic       mem_sb_en,
    output logic       mem_sel,
    output logic       fault,
    output logic [1:0] pstate
);
    localparam int unsigned N_REQ = 2;

    logic              por_ok, v12_ok, msel_due, flt_due;
    logic              por_q, shdn_q, run, cap_cfg, msel_done;
    logic [1:0]        cfg_q;
    logic [N_REQ-1:0]  req_raw, req_flt;
    logic [N_RAIL-1:0] rail_on, rail_rdy;
    logic              flt_cond;
    seq_st_t           state_q;
    logic              sleep_entry;
    rail_en_t          en_q;

    // Supply qualifiers: power-on-reset extension and 12 V assessment.
    sc_qualify #(.LIMIT(POR_EXT_CYC))  u_por  (.clk(clk), .rst_n(rst_n), .din(sb_good),  .qual(por_ok));
    sc_qualify #(.LIMIT(V12_QUAL_CYC)) u_v12  (.clk(clk), .rst_n(rst_n), .din(v12_good), .qual(v12_ok));
    sc_qualify #(.LIMIT(MSEL_DLY_CYC)) u_msel (.clk(clk), .rst_n(rst_n), .din(por_ok),   .qual(msel_due));

    // Request filters, one per sleep line.
    assign req_raw = {slp5_n, slp3_n};
    for (genvar gi = 0; gi < N_REQ; gi++) begin : g_req
        sc_deglitch #(.DGL_CYC(DGL_CYC), .RST_VAL(1'b1)) u_dgl (
            .clk(clk), .rst_n(rst_n), .din(req_raw[gi]), .dout(req_flt[gi]));
    end

    assign run = por_ok && !shdn;

    sc_fsm #(.SKEW_CYC(SKEW_CYC)) u_fsm (
        .clk(clk), .rst_n(rst_n), .run(run),
        .s3n(req_flt[0]), .s5n(req_flt[1]),
        .state_q(state_q), .sleep_entry(sleep_entry));

    // Edge history for power-on-reset release and shutdown release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            por_q  <= 1'b0;
            shdn_q <= 1'b0;
        end else begin
            por_q  <= por_ok;
            shdn_q <= shdn;
        end
    end

    assign cap_cfg = sleep_entry || (por_ok && !por_q) || (!shdn && shdn_q);

    // Configuration capture at the three allowed instants only.
    always_ff @(posedge clk) begin
        if (!rst_n)       cfg_q <= 2'b00;
        else if (cap_cfg) cfg_q <= {cfg_en5, cfg_en3};
    end

    // One-time memory select capture after power-on-reset release.
    always_ff @(posedge clk) begin
        if (!rst_n || !por_ok) begin
            mem_sel   <= 1'b0;
            msel_done <= 1'b0;
        end else if (msel_due && !msel_done) begin
            mem_sel   <= msel_in;
            msel_done <= 1'b1;
        end
    end

    // Per-rail settling windows that gate the under-voltage flags.
    assign rail_on = {en_q.mem_act | en_q.mem_sb,
                      en_q.v5_act  | en_q.v5_sb,
                      en_q.v3_act  | en_q.v3_sb};
    for (genvar gr = 0; gr < N_RAIL; gr++) begin : g_ramp
        sc_qualify #(.LIMIT(RAMP_CYC)) u_ramp (
            .clk(clk), .rst_n(rst_n), .din(rail_on[gr]), .qual(rail_rdy[gr]));
    end

    assign flt_cond = run && (ot_flag || |(uv_flag & rail_rdy));

    sc_qualify #(.LIMIT(FLT_DLY_CYC)) u_flt (.clk(clk), .rst_n(rst_n), .din(flt_cond), .qual(flt_due));

    // Sticky fault, cleared only by shutdown or loss of power-on reset.
    always_ff @(posedge clk) begin
        if (!rst_n || !por_ok || shdn) fault <= 1'b0;
        else if (flt_due)              fault <= 1'b1;
    end

    // Rail switch register decoded from the sequencer state.
    always_ff @(posedge clk) begin
        if (!rst_n || shdn || fault || !por_ok) begin
            en_q <= '0;
        end else begin
            en_q <= '0;
            case (state_q)
                ST_ACT, ST_SKEW: begin
                    en_q.v3_act  <= v12_ok;
                    en_q.v5_act  <= v12_ok;
                    en_q.mem_act <= v12_ok;
                end
                ST_SLP3: begin
                    en_q.v3_sb  <= cfg_q[0];
                    en_q.v5_sb  <= cfg_q[1];
                    en_q.mem_sb <= 1'b1;
                end
                ST_SLP5: begin
                    en_q.v3_sb <= cfg_q[0];
                    en_q.v5_sb <= cfg_q[1];
                end
                default: en_q <= '0;
            endcase
        end
    end

    assign rail3_act_en = en_q.v3_act;
    assign rail3_sb_en  = en_q.v3_sb;
    assign rail5_act_en = en_q.v5_act;
    assign rail5_sb_en  = en_q.v5_sb;
    assign mem_act_en   = en_q.mem_act;
    assign mem_sb_en    = en_q.mem_sb;

    // Reported state code.
    always_comb begin
        case (state_q)
            ST_ACT, ST_SKEW: pstate = PS_ACT;
            ST_SLP3:         pstate = PS_S3;
            ST_SLP5:         pstate = PS_S5;
            default:         pstate = PS_OFF;
        endcase
    end

    p_break_before_make_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(rail3_act_en && rail3_sb_en) && !(rail5_act_en && rail5_sb_en) && !(mem_act_en && mem_sb_en));

    p_shdn_all_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
        shdn |=> !(rail3_act_en || rail3_sb_en || rail5_act_en || rail5_sb_en || mem_act_en || mem_sb_en));

    p_fault_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (fault && por_ok && !shdn) |=> fault);

    p_msel_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (msel_done && $past(msel_done)) |-> $stable(mem_sel));

    p_act_needs_12v_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rail3_act_en) |-> $past(v12_ok));

endmodule

// File: tb/sleep_seq_ctrl_test.sv
// Bench: boot sequence, a table of request/configuration vectors, then
// directed cases for glitches, masking, fault and shutdown.
module sleep_seq_ctrl_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sb_good = 1'b0, v12_good = 1'b0;
    logic       slp3_n = 1'b1, slp5_n = 1'b1;
    logic       cfg_en3 = 1'b1, cfg_en5 = 1'b1;
    logic       msel_in = 1'b1, shdn = 1'b0, ot_flag = 1'b0;
    logic [2:0] uv_flag = 3'b000;
    logic       rail3_act_en, rail3_sb_en, rail5_act_en, rail5_sb_en;
    logic       mem_act_en, mem_sb_en, mem_sel, fault;
    logic [1:0] pstate;
    logic [5:0] en_bus;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    sleep_seq_ctrl #(
        .POR_EXT_CYC(20), .V12_QUAL_CYC(30), .MSEL_DLY_CYC(10), .SKEW_CYC(16),
        .DGL_CYC(4), .FLT_DLY_CYC(8), .RAMP_CYC(6), .N_RAIL(3)
    ) uut (
        .clk(clk), .rst_n(rst_n), .sb_good(sb_good), .v12_good(v12_good),
        .slp3_n(slp3_n), .slp5_n(slp5_n), .cfg_en3(cfg_en3), .cfg_en5(cfg_en5),
        .msel_in(msel_in), .shdn(shdn), .uv_flag(uv_flag), .ot_flag(ot_flag),
        .rail3_act_en(rail3_act_en), .rail3_sb_en(rail3_sb_en),
        .rail5_act_en(rail5_act_en), .rail5_sb_en(rail5_sb_en),
        .mem_act_en(mem_act_en), .mem_sb_en(mem_sb_en),
        .mem_sel(mem_sel), .fault(fault), .pstate(pstate));

    assign en_bus = {rail3_act_en, rail3_sb_en, rail5_act_en, rail5_sb_en, mem_act_en, mem_sb_en};

    // Vector: {slp3_n, slp5_n, cfg_en3, cfg_en5, wait[7:0], pstate[1:0], en_bus[5:0]}
    localparam int NVEC = 11;
    localparam logic [19:0] VEC [NVEC] = '{
        {4'b1111, 8'd40, 2'd1, 6'b101010},  // R1 active
        {4'b0011, 8'd40, 2'd3, 6'b010100},  // R1 R6 S4/S5
        {4'b0111, 8'd40, 2'd3, 6'b010100},  // R2 S3 request ignored
        {4'b1101, 8'd40, 2'd1, 6'b101010},  // R1 back to active
        {4'b0101, 8'd60, 2'd2, 6'b000101},  // R1 R6 S3 after window
        {4'b0001, 8'd40, 2'd2, 6'b000101},  // R2 S4/S5 request ignored
        {4'b1110, 8'd40, 2'd1, 6'b101010},  // R1 active
        {4'b0110, 8'd6,  2'd1, 6'b101010},  // R3 inside skew window
        {4'b0010, 8'd40, 2'd3, 6'b010000},  // R3 resolves to S4/S5
        {4'b0001, 8'd40, 2'd3, 6'b010000},  // R5 config change asleep ignored
        {4'b1111, 8'd40, 2'd1, 6'b101010}   // R1 active again
    };

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Watchdog: ends a hung run as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        step(5);
        chk("R9 reset pstate", pstate, 0);
        chk("R9 reset switches", en_bus, 0);
        chk("R9 reset fault", fault, 0);
        rst_n = 1'b1;
        step(1);
        sb_good = 1'b1;
        step(15);
        chk("R9 still off inside extension", pstate, 0);
        step(10);
        chk("R9 active after extension", pstate, 1);
        chk("R8 active switches off before 12V", en_bus, 0);
        step(15);
        msel_in = 1'b0;
        step(5);
        chk("R7 memory select held", mem_sel, 1);
        v12_good = 1'b1;
        step(20);
        chk("R8 still off inside 12V window", en_bus, 0);
        step(20);
        chk("R8 active switches on", en_bus, 6'b101010);

        for (int i = 0; i < NVEC; i++) begin
            {slp3_n, slp5_n, cfg_en3, cfg_en5} = VEC[i][19:16];
            step(int'(VEC[i][15:8]));
            chk($sformatf("R1/R2/R3/R5 vector %0d pstate", i), pstate, int'(VEC[i][7:6]));
            chk($sformatf("R6 vector %0d switches", i), en_bus, int'(VEC[i][5:0]));
        end

        // R4: both lines low for 3 cycles, watched every cycle after.
        begin
            int bad = 0;
            slp3_n = 1'b0; slp5_n = 1'b0;
            step(3);
            slp3_n = 1'b1; slp5_n = 1'b1;
            for (int k = 0; k < 12; k++) begin
                step(1);
                if (pstate != 2'd1) bad++;
            end
            chk("R4 short glitch ignored", bad, 0);
        end

        // R13: memory under-voltage in S4/S5, memory rail off.
        slp3_n = 1'b0; slp5_n = 1'b0;
        step(40);
        uv_flag = 3'b100;
        step(40);
        chk("R13 masked under-voltage", fault, 0);
        chk("R13 switches unchanged", en_bus, 6'b010100);
        uv_flag = 3'b000;
        slp3_n = 1'b1; slp5_n = 1'b1;
        step(40);

        // R10: short pulse, then persistent under-voltage.
        uv_flag = 3'b100;
        step(4);
        uv_flag = 3'b000;
        step(20);
        chk("R10 short under-voltage no fault", fault, 0);
        uv_flag = 3'b100;
        step(30);
        chk("R10 fault raised", fault, 1);
        chk("R10 switches off on fault", en_bus, 0);
        uv_flag = 3'b000;
        step(10);
        chk("R10 fault sticky", fault, 1);

        // R11: shutdown clears everything, release returns to active.
        shdn = 1'b1;
        step(5);
        chk("R11 pstate off in shutdown", pstate, 0);
        chk("R11 fault cleared", fault, 0);
        chk("R11 switches off", en_bus, 0);
        shdn = 1'b0;
        step(20);
        chk("R11 active after release", pstate, 1);
        chk("R11 switches restored", en_bus, 6'b101010);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule